// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer with a small register interface. It has a 16-bit up-counter that counts prescaled ticks from one of three count sources. Each source is a single-cycle enable that has already been brought into the system clock domain. A 3-bit prescaler code divides the selected source by a power of four, from 1 up to 1024. When the running counter reaches a programmed limit, the block drives a single-cycle reset request toward the chip reset logic.

Software sets up the block in this order: stop the counter, choose a prescaler with no source selected, write the limit, clear the counter, select a source, then start the counter. Software services the watchdog by writing zero to the count register. Every register reads back its current value, and bits with no function read as zero.

Top module: `pscl_watchdog`

## Requirements
- R1: After reset the limit register reads 0xFFFF, and the run, count and mode registers read 0. `rst_req` is low.
- R2: Address bits 3:2 select the register: 0 is the limit, 1 is run (bit 0 only), 2 is the count and 3 is the mode (bits 5:0). A read returns the current value with the unused upper bits as zero.
- R3: Mode bits 2:0 select the count source one-hot. Bit 0 selects `src_tick[0]`, bit 1 selects `src_tick[1]` and bit 2 selects `src_tick[2]`. When no bit is set, or when more than one is set, the counter holds.
- R4: Mode bits 5:3 hold the prescaler code c. The counter advances once per 4^c pulses of the selected source, and codes 6 and 7 divide by 1024. The counter never moves by more than one per cycle.
- R5: The counter advances only while run bit 0 is 1. Clearing run holds the count and clears the prescaler.
- R6: A write to the count register loads the written value, and writing zero services the watchdog. The write also clears the prescaler, so the first advance after it needs a full prescaler period.
- R7: A write to the mode register clears the prescaler.
- R8: When run is 1 and the count equals the limit, `rst_req` is high for exactly one cycle, in the cycle after that state. The counter holds at the limit.
- R9: After a request, no further request is raised until the count or the limit register is written. A rewrite of the limit with the same value re-arms the request.
- R10: A write to the count or limit register in the cycle where a request would be decided suppresses that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | Single-cycle count-source enables, synchronous to clk |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at bus_addr (combinational) |
| rst_req | output | 1 | Single-cycle reset request on expiry |

## Verification
The assertions assume that `src_tick` is synchronous to `clk`, that any combination of its bits may be high in any cycle, and that each cycle carries at most one register write. The bench drives `src_tick` from random words and from directed bursts on selected and unselected sources. It issues writes only through a task that holds the strobe for a single cycle. During the random phase it keeps the limit and count values small and the prescaler codes low, so that expiry, servicing and re-arming occur often within the run.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
    localparam int unsigned SRC_N  = 3;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned CTL_W  = SRC_N + CODE_W;

    typedef enum logic [1:0] {
        SLOT_LIMIT = 2'd0,
        SLOT_RUN   = 2'd1,
        SLOT_COUNT = 2'd2,
        SLOT_MODE  = 2'd3
    } slot_e;
endpackage

// File: rtl/pscl_src_pick.sv
module pscl_src_pick #(
    parameter int unsigned SRC_N = 3
) (
    input  logic [SRC_N-1:0] sel,
    input  logic [SRC_N-1:0] ticks,
    output logic             pulse
);
    logic [SRC_N-1:0] hit;
    logic             sel_ok;

    for (genvar g = 0; g < SRC_N; g++) begin : g_hit
        assign hit[g] = sel[g] & ticks[g];
    end

    // exactly one source bit may be set
    assign sel_ok = (sel != '0) && ((sel & (sel - 1'b1)) == '0);

    always_comb begin
        pulse = sel_ok && (|hit);
    end
endmodule

// File: rtl/pscl_prescale.sv
module pscl_prescale #(
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned MAX_CODE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int unsigned PRE_W = 2 * MAX_CODE;

    typedef struct packed {
        logic [PRE_W-1:0] pcnt;
    } pre_t;

    pre_t             st_d, st_q;
    logic [PRE_W-1:0] mask;
    int unsigned      eff;

    always_comb begin
        // codes above the largest supported divide clamp to it
        eff  = (int'(code) > int'(MAX_CODE)) ? MAX_CODE : int'(code);
        mask = {PRE_W{1'b1}} >> (PRE_W - 2 * eff);
        tick = step && (st_q.pcnt == mask);
        st_d = st_q;
        if (clr) begin
            st_d.pcnt = '0;
        end else if (step) begin
            st_d.pcnt = tick ? '0 : st_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pscl_core.sv
module pscl_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic             lim_wr,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             spent;
        logic             req;
    } core_t;

    core_t st_d, st_q;
    logic  at_lim;
    logic  fire;

    always_comb begin
        at_lim = (st_q.cnt == limit);
        fire   = run && at_lim && !st_q.spent && !cnt_wr && !lim_wr;
        st_d   = st_q;
        st_d.req = fire;
        if (cnt_wr) begin
            st_d.cnt = cnt_wdata;
        end else if (tick && !at_lim) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (cnt_wr || lim_wr) begin
            st_d.spent = 1'b0;
        end else if (fire) begin
            st_d.spent = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign rst_req = st_q.req;
endmodule

// File: rtl/pscl_watchdog.sv
module pscl_watchdog #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned MAX_CODE = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [pscl_pkg::SRC_N-1:0] src_tick,
    input  logic                     bus_en,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     rst_req
);
    import pscl_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic             run;
        logic [CTL_W-1:0] mode;
    } regs_t;

    regs_t            r_d, r_q;
    slot_e            slot;
    logic             wr;
    logic             lim_wr, run_wr, cnt_wr, mode_wr;
    logic             src_pulse, step, pre_clr, pre_tick;
    logic [CNT_W-1:0] cnt_val;
    logic [1:0]       unused_addr;

    assign unused_addr = bus_addr[1:0];

    always_comb begin
        slot    = slot_e'(bus_addr[3:2]);
        wr      = bus_en && bus_we;
        lim_wr  = wr && (slot == SLOT_LIMIT);
        run_wr  = wr && (slot == SLOT_RUN);
        cnt_wr  = wr && (slot == SLOT_COUNT);
        mode_wr = wr && (slot == SLOT_MODE);

        r_d = r_q;
        if (lim_wr)  r_d.limit = bus_wdata[CNT_W-1:0];
        if (run_wr)  r_d.run   = bus_wdata[0];
        if (mode_wr) r_d.mode  = bus_wdata[CTL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.limit <= '1;
            r_q.run   <= 1'b0;
            r_q.mode  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (slot)
            SLOT_LIMIT: bus_rdata = DATA_W'(r_q.limit);
            SLOT_RUN:   bus_rdata = DATA_W'(r_q.run);
            SLOT_COUNT: bus_rdata = DATA_W'(cnt_val);
            SLOT_MODE:  bus_rdata = DATA_W'(r_q.mode);
            default:    bus_rdata = '0;
        endcase
    end

    pscl_src_pick #(.SRC_N(SRC_N)) u_pick (
        .sel   (r_q.mode[SRC_N-1:0]),
        .ticks (src_tick),
        .pulse (src_pulse)
    );

    assign step    = r_q.run && src_pulse;
    assign pre_clr = cnt_wr || mode_wr || !r_q.run;

    pscl_prescale #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .step  (step),
        .code  (r_q.mode[CTL_W-1:SRC_N]),
        .tick  (pre_tick)
    );

    pscl_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (r_q.run),
        .tick      (pre_tick),
        .limit     (r_q.limit),
        .lim_wr    (lim_wr),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (bus_wdata[CNT_W-1:0]),
        .cnt       (cnt_val),
        .rst_req   (rst_req)
    );
endmodule

// File: rtl/pscl_watchdog_chk.sv
module pscl_watchdog_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned CTL_W = 6,
    parameter int unsigned SRC_N = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CNT_W-1:0] limit,
    input logic [CNT_W-1:0] cnt,
    input logic [CTL_W-1:0] mode,
    input logic             cnt_wr,
    input logic             lim_wr,
    input logic             rst_req
);
    logic             fired_q;
    logic             src_ok;
    logic [CNT_W-1:0] cnt_next;

    assign src_ok   = $onehot(mode[SRC_N-1:0]);
    assign cnt_next = cnt + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
        end else if (cnt_wr || lim_wr) begin
            fired_q <= 1'b0;
        end else if (rst_req) begin
            fired_q <= 1'b1;
        end
    end

    // R8
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8
    req_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(run && (cnt == limit)));

    // R8
    hold_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == limit) && !cnt_wr) |=> $stable(cnt));

    // R9
    no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && !cnt_wr && !lim_wr) |=> !rst_req);

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    // R3
    bad_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ok && !cnt_wr) |=> $stable(cnt));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt_next))));
endmodule

bind pscl_watchdog pscl_watchdog_chk #(
    .CNT_W (CNT_W),
    .CTL_W (pscl_pkg::CTL_W),
    .SRC_N (pscl_pkg::SRC_N)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (r_q.run),
    .limit   (r_q.limit),
    .cnt     (cnt_val),
    .mode    (r_q.mode),
    .cnt_wr  (cnt_wr),
    .lim_wr  (lim_wr),
    .rst_req (rst_req)
);

// File: tb/sim_pscl_watchdog.sv
`timescale 1ns/1ps
module sim_pscl_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_tick = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pscl_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    // reference model built from the requirements
    logic [15:0] m_lim, m_cnt;
    logic        m_run, m_exp, m_req;
    logic [5:0]  m_mode;
    int          m_pc;

    function automatic int div_of(input logic [2:0] c);
        return (c > 3'd5) ? 1024 : (1 << (2 * c));
    endfunction

    function automatic logic [15:0] model_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_lim;
            2'd1: return {15'd0, m_run};
            2'd2: return m_cnt;
            default: return {10'd0, m_mode};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lim = 16'hFFFF; m_cnt = '0; m_run = 0; m_exp = 0; m_req = 0;
            m_mode = '0; m_pc = 0;
        end else begin
            automatic logic wr   = bus_en && bus_we;
            automatic logic wlim = wr && bus_addr[3:2] == 2'd0;
            automatic logic wrun = wr && bus_addr[3:2] == 2'd1;
            automatic logic wcnt = wr && bus_addr[3:2] == 2'd2;
            automatic logic wmod = wr && bus_addr[3:2] == 2'd3;
            automatic logic [2:0] s = m_mode[2:0];
            automatic logic one = (s == 3'b001) || (s == 3'b010) || (s == 3'b100);
            automatic logic stp = m_run && one && |(s & src_tick);
            automatic logic ptk = stp && (m_pc == div_of(m_mode[5:3]) - 1);
            automatic logic at  = (m_cnt == m_lim);
            automatic logic fire = m_run && at && !m_exp && !wcnt && !wlim;
            if (wcnt || wmod || !m_run) m_pc = 0;
            else if (stp) m_pc = ptk ? 0 : m_pc + 1;
            if (wcnt) m_cnt = bus_wdata;
            else if (ptk && !at) m_cnt = m_cnt + 16'd1;
            if (wcnt || wlim) m_exp = 0;
            else if (fire) m_exp = 1;
            m_req = fire;
            if (wlim) m_lim = bus_wdata;
            if (wrun) m_run = bus_wdata[0];
            if (wmod) m_mode = bus_wdata[5:0];
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // scoreboard: every cycle, after inputs settle
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            check(rst_req == m_req, "R8 request vs model", rst_req, m_req);
            check(bus_rdata == model_read(bus_addr), "R2 readback vs model",
                  bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(input logic [1:0] slot, input logic [15:0] d);
        bus_en = 1; bus_we = 1; bus_addr = {slot, 2'b00}; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [1:0] slot, output logic [15:0] v);
        bus_addr = {slot, 2'b00};
        #1 v = bus_rdata;
    endtask

    task automatic pulse(input logic [2:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            src_tick = m;
            @(negedge clk);
        end
        src_tick = '0;
    endtask

    task automatic expect_cnt(input logic [15:0] e, input string tag);
        logic [15:0] v;
        rd(2'd2, v);
        check(v == e, tag, v, e);
    endtask

    task automatic program_wd(input logic [15:0] lim, input logic [5:0] mode);
        wr(2'd1, 16'd0);
        wr(2'd3, {10'd0, mode[5:3], 3'b000});
        wr(2'd0, lim);
        wr(2'd2, 16'd0);
        wr(2'd3, {10'd0, mode});
        wr(2'd1, 16'd1);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired (all requirements) act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset values
        rd(2'd0, v); check(v == 16'hFFFF, "R1 limit reset", v, 16'hFFFF);
        rd(2'd1, v); check(v == 16'd0, "R1 run reset", v, 0);
        rd(2'd2, v); check(v == 16'd0, "R1 count reset", v, 0);
        rd(2'd3, v); check(v == 16'd0, "R1 mode reset", v, 0);
        check(rst_req == 1'b0, "R1 rst_req reset", rst_req, 0);

        // R2 field widths and unused bits
        wr(2'd3, 16'hFFFF); rd(2'd3, v); check(v == 16'h003F, "R2 mode bits", v, 16'h3F);
        wr(2'd1, 16'hFFFE); rd(2'd1, v); check(v == 16'h0000, "R2 run bit0 clear", v, 0);
        wr(2'd1, 16'h0003); rd(2'd1, v); check(v == 16'h0001, "R2 run bit0 set", v, 1);
        wr(2'd0, 16'h1234); rd(2'd0, v); check(v == 16'h1234, "R2 limit", v, 16'h1234);

        // divide by 1, source 0, limit 5
        program_wd(16'd5, 6'b000_001);
        pulse(3'b001, 3);  expect_cnt(16'd3, "R4 divide by one");
        pulse(3'b110, 6);  expect_cnt(16'd3, "R3 unselected sources ignored");
        pulse(3'b001, 2);  expect_cnt(16'd5, "R8 reach limit");
        check(rst_req == 0, "R8 request not yet", rst_req, 0);
        @(negedge clk);
        check(rst_req == 1, "R8 request raised", rst_req, 1);
        @(negedge clk);
        check(rst_req == 0, "R8 request one cycle", rst_req, 0);
        for (int i = 0; i < 10; i++) begin
            src_tick = 3'b001;
            @(negedge clk);
            check(rst_req == 0, "R9 no repeat request", rst_req, 0);
        end
        src_tick = '0;
        expect_cnt(16'd5, "R8 holds at limit");
        wr(2'd0, 16'd5);
        check(rst_req == 0, "R10 limit write blocks", rst_req, 0);
        @(negedge clk);
        check(rst_req == 1, "R9 limit rewrite re-arms", rst_req, 1);
        @(negedge clk);

        wr(2'd2, 16'd0); expect_cnt(16'd0, "R6 service clears");

        // divide by 4, source 1
        wr(2'd3, 16'b001_010);
        pulse(3'b010, 3); expect_cnt(16'd0, "R4 divide by four partial");
        pulse(3'b010, 1); expect_cnt(16'd1, "R4 divide by four step");
        pulse(3'b010, 8); expect_cnt(16'd3, "R4 divide by four run");
        wr(2'd2, 16'd0);

        pulse(3'b010, 2); wr(2'd2, 16'd0);
        pulse(3'b010, 3); expect_cnt(16'd0, "R6 prescaler cleared by service");
        pulse(3'b010, 1); expect_cnt(16'd1, "R6 full period after service");

        pulse(3'b010, 2); wr(2'd3, 16'b001_010);
        pulse(3'b010, 3); expect_cnt(16'd1, "R7 prescaler cleared by mode write");
        pulse(3'b010, 1); expect_cnt(16'd2, "R7 full period after mode write");

        pulse(3'b010, 2); wr(2'd1, 16'd0);
        pulse(3'b010, 10); expect_cnt(16'd2, "R5 stopped counter holds");
        wr(2'd1, 16'd1);
        pulse(3'b010, 3); expect_cnt(16'd2, "R5 prescaler cleared by stop");
        pulse(3'b010, 1); expect_cnt(16'd3, "R5 counts after restart");

        wr(2'd3, 16'b000_011);
        pulse(3'b111, 5); expect_cnt(16'd3, "R3 two sources hold");
        wr(2'd3, 16'b000_000);
        pulse(3'b111, 5); expect_cnt(16'd3, "R3 no source holds");

        wr(2'd3, 16'b111_001);
        pulse(3'b001, 1023); expect_cnt(16'd3, "R4 code 7 partial");
        pulse(3'b001, 1);    expect_cnt(16'd4, "R4 code 7 as 1024");
        wr(2'd3, 16'b101_100);
        pulse(3'b100, 1023); expect_cnt(16'd4, "R4 code 5 partial");
        pulse(3'b100, 1);    expect_cnt(16'd5, "R4 code 5 is 1024");
        repeat (3) @(negedge clk);

        // R10: service in the deciding cycle suppresses the request
        wr(2'd0, 16'd9); wr(2'd2, 16'd8); wr(2'd3, 16'b000_001);
        pulse(3'b001, 1); expect_cnt(16'd9, "R10 at limit");
        wr(2'd2, 16'd0);
        check(rst_req == 0, "R10 service blocks request", rst_req, 0);
        @(negedge clk);
        check(rst_req == 0, "R10 no late request", rst_req, 0);

        // random phase, checked by the model scoreboard
        for (int i = 0; i < 4000; i++) begin
            automatic logic [1:0] slot = 2'($urandom % 4);
            src_tick = 3'($urandom);
            bus_addr = {slot, 2'($urandom)};
            bus_en = ($urandom % 6) == 0;
            bus_we = ($urandom % 5) != 0;
            case (slot)
                2'd0: bus_wdata = 16'($urandom % 24);
                2'd1: bus_wdata = {15'($urandom), 1'(($urandom % 5) != 0)};
                2'd2: bus_wdata = 16'($urandom % 20);
                default: bus_wdata = {10'($urandom), 3'($urandom % 3),
                    (($urandom % 4) == 0) ? 3'($urandom) : 3'(1 << ($urandom % 3))};
            endcase
            @(negedge clk);
        end
        bus_en = 0; src_tick = '0;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule